// File: doc/BRIEF.md
# Over-Charge Protection Controller

This block is the digital sequencer for a single-cell battery guard. It drives an active-high charge-enable line to the gate driver of an external charge FET. Three comparator results arrive as already-digitised flags: the cell is above the over-charge detect level, the cell is below the lower release level, and a load is attached while no charger is present. The block resamples all three flags into its own clock domain. It then decides when charging must stop and when it may start again.

A rise above the detect level starts a confirmation delay. The delay is counted in ticks of a slow timebase. If the level stays above the detect threshold for the whole delay, charging is switched off. If it falls back early, the event is treated as a glitch and nothing happens. Charging is allowed again in two ways. The first is plain hysteresis: the cell drops below the release level. The second is load-assisted: a load draws the cell below the detect level while no charger is attached. The analog comparators, the level shifting and the output driver are outside this block.

Top module: `ocp_guard`

## Requirements
- R1: After reset the controller is in its normal state and `chg_en_o` is 1.
- R2: When `above_det_i` stays 1 and `DELAY_TICKS` timebase ticks are counted while the controller is in its delay state, `chg_en_o` goes to 0.
- R3: If `above_det_i` returns to 0 before the delay has been counted out, `chg_en_o` stays 1.
- R4: While charging is off, `below_rel_i` = 1 releases the controller and `chg_en_o` returns to 1.
- R5: While charging is off, `load_only_i` = 1 together with `above_det_i` = 0 releases the controller. This applies inside the hysteresis band (`below_rel_i` = 0) and so covers the load pulling the cell under the detect level.
- R6: While charging is off and `above_det_i` = 1, `load_only_i` has no effect: `chg_en_o` stays 0.
- R7: While charging is off and the cell is inside the band with `load_only_i` = 0, `chg_en_o` stays 0.
- R8: The delay count clears whenever the above-detect flag drops. Several short above-detect episodes, each shorter than the delay, never switch charging off.
- R9: Without timebase ticks the delay does not advance, so `chg_en_o` stays 1 however long `above_det_i` is held.
- R10: Each input passes through a two-flop synchroniser and then the state register. A change on an input pin can show on `chg_en_o` at the third rising clock edge after it is applied, and no earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle timebase pulse that advances the detect delay |
| above_det_i | input | 1 | Cell voltage is above the over-charge detect level |
| below_rel_i | input | 1 | Cell voltage is below the release level |
| load_only_i | input | 1 | A load is attached and no charger is present |
| chg_en_o | output | 1 | Charge enable: 1 lets the charge FET conduct, 0 switches it off |

## Verification
The hardest situation to reach is a detection that almost completes and then collapses. This is an above-detect episode that ends one tick short of the delay, followed at once by another such episode. A counter that failed to clear would then switch charging off wrongly. The bench builds this on purpose with back-to-back bursts sized from the delay parameter. It also runs random sequences in which the voltage level, the load flag and the tick are held for short random stretches, so near-miss bursts and releases in both ways happen many times. Every cycle is compared against a bench model built from the requirements, including the three-edge input latency.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DELAY  = 2'd1,
    ST_OC     = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ocp_delay_cnt.sv
module ocp_delay_cnt #(
  parameter int DELAY_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == LIMIT);
  assign cnt_en = !run_i || (tick_i && !done_o);

  always_comb begin
    if (!run_i) cnt_d = '0;
    else        cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_fsm.sv
module ocp_fsm
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_s,
  input  logic       below_s,
  input  logic       load_s,
  input  logic       cnt_done,
  output logic       cnt_run,
  output ocp_state_e state_q,
  output logic       chg_en_o
);
  ocp_state_e state_d;
  logic       release_req;

  assign release_req = below_s || (load_s && !above_s);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: if (above_s) state_d = ST_DELAY;
      ST_DELAY: begin
        if (!above_s)     state_d = ST_NORMAL;
        else if (cnt_done) state_d = ST_OC;
      end
      ST_OC:     if (release_req) state_d = ST_NORMAL;
      default:   state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign cnt_run  = (state_q == ST_DELAY) && above_s;
  assign chg_en_o = (state_q != ST_OC);
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int DELAY_TICKS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic above_det_i,
  input  logic below_rel_i,
  input  logic load_only_i,
  output logic chg_en_o
);
  localparam int NFLAG = 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [NFLAG-1:0] flags_s;
  logic             above_s, below_s, load_s;
  logic             cnt_run, cnt_done;
  ocp_state_e       state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ocp_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({load_only_i, below_rel_i, above_det_i}),
    .q_o   (flags_s)
  );
  assign above_s = flags_s[0];
  assign below_s = flags_s[1];
  assign load_s  = flags_s[2];

  ocp_delay_cnt #(.DELAY_TICKS(DELAY_TICKS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (cnt_run),
    .tick_i (tick_i),
    .done_o (cnt_done)
  );

  ocp_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .above_s  (above_s),
    .below_s  (below_s),
    .load_s   (load_s),
    .cnt_done (cnt_done),
    .cnt_run  (cnt_run),
    .state_q  (state_q),
    .chg_en_o (chg_en_o)
  );
endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk
  import ocp_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input ocp_state_e state_q,
  input logic       above_s,
  input logic       below_s,
  input logic       load_s,
  input logic       cnt_done,
  input logic       chg_en_o
);
  a_r1_no_direct_trip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_NORMAL) |=> (state_q != ST_OC));

  a_r2_trip_needs_delay: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DELAY && !(cnt_done && above_s)) |=> (state_q != ST_OC));

  a_r3_glitch_returns: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DELAY && !above_s) |=> (state_q == ST_NORMAL && chg_en_o));

  a_r4_hyst_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_OC && below_s) |=> chg_en_o);

  a_r5_load_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_OC && load_s && !above_s) |=> chg_en_o);

  a_r6_hold_above: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_OC && above_s && !below_s) |=> !chg_en_o);

  a_r7_hold_band: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_OC && !above_s && !below_s && !load_s) |=> !chg_en_o);
endmodule

bind ocp_guard ocp_guard_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .state_q    (state_q),
  .above_s    (above_s),
  .below_s    (below_s),
  .load_s     (load_s),
  .cnt_done   (cnt_done),
  .chg_en_o   (chg_en_o)
);

// File: tb/sim_ocp_guard.sv
`timescale 1ns/1ps
module sim_ocp_guard;
  localparam int DT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, above_det_i = 1'b0, below_rel_i = 1'b0, load_only_i = 1'b0;
  logic chg_en_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tick_mode = 1;
  string tag = "R1";

  // bench model: 0 normal, 1 delay, 2 off
  logic [2:0] m_s1, m_s2;
  int m_state, m_cnt;

  ocp_guard #(.DELAY_TICKS(DT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .above_det_i(above_det_i),
    .below_rel_i(below_rel_i), .load_only_i(load_only_i), .chg_en_o(chg_en_o)
  );

  always #5 clk = ~clk;

  function automatic int next_state(int st, logic [2:0] s, int cnt);
    logic above = s[0];
    logic below = s[1];
    logic load  = s[2];
    case (st)
      0: return above ? 1 : 0;
      1: return !above ? 0 : (cnt == DT ? 2 : 1);
      default: return (below || (load && !above)) ? 0 : 2;
    endcase
  endfunction

  function automatic int next_cnt(int st, logic [2:0] s, int cnt, logic tk);
    if (!(st == 1 && s[0])) return 0;
    if (tk && cnt < DT) return cnt + 1;
    return cnt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_state = 0; m_cnt = 0;
    end else begin
      int ns, nc;
      ns = next_state(m_state, m_s2, m_cnt);
      nc = next_cnt(m_state, m_s2, m_cnt, tick_i);
      m_state = ns; m_cnt = nc;
      m_s2 = m_s1;
      m_s1 = {load_only_i, below_rel_i, above_det_i};
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic exp);
    checks++;
    if (chg_en_o !== exp) begin
      errors++;
      $display("FAIL %s: chg_en_o actual=%b expected=%b at cycle %0d", req, chg_en_o, exp, cycles);
    end
  endtask

  // level: 0 below release, 1 inside band, 2 above detect
  task automatic set_in(int lvl, logic load);
    above_det_i = (lvl == 2);
    below_rel_i = (lvl == 0);
    load_only_i = load;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, (m_state != 2));
      case (tick_mode)
        0:       tick_i = 1'b0;
        1:       tick_i = 1'b1;
        default: tick_i = ($urandom % 2) == 0;
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    set_in(1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; tick_mode = 1;
    run(6);
    check("R1", 1'b1);

    // R10: detection appears exactly after sync + delay; model checks every cycle
    tag = "R10"; set_in(2, 1'b0);
    run(2);
    check("R10", 1'b1);
    tag = "R2"; run(10);
    check("R2", 1'b0);

    tag = "R6"; set_in(2, 1'b1); run(6);
    check("R6", 1'b0);

    tag = "R7"; set_in(1, 1'b0); run(8);
    check("R7", 1'b0);

    tag = "R5"; set_in(1, 1'b1); run(2);
    check("R10", 1'b0);
    run(4);
    check("R5", 1'b1);

    tag = "R3"; set_in(1, 1'b0); run(3);
    set_in(2, 1'b0); run(3);
    set_in(1, 1'b0); run(8);
    check("R3", 1'b1);

    // R8: back-to-back bursts each one tick short of the delay
    tag = "R8";
    for (int k = 0; k < 4; k++) begin
      set_in(2, 1'b0); run(DT);
      set_in(1, 1'b0); run(1);
    end
    run(6);
    check("R8", 1'b1);

    tag = "R9"; tick_mode = 0; set_in(2, 1'b0); run(30);
    check("R9", 1'b1);
    tag = "R2"; tick_mode = 1; run(10);
    check("R2", 1'b0);

    tag = "R4"; set_in(0, 1'b0); run(6);
    check("R4", 1'b1);

    tag = "R10"; tick_mode = 2;
    for (int seg = 0; seg < 600; seg++) begin
      int lvl;
      lvl = $urandom % 3;
      if (($urandom % 4) == 0) lvl = 2;
      set_in(lvl, ($urandom % 3) == 0);
      run(1 + ($urandom % (DT + 4)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule